// File: doc/BRIEF.md
# Phase and Efficiency Mode Controller

This block is the digital mode controller of a two-phase buck regulator. Three power-saving select inputs are decoded into one of three operating modes: both phases switching in continuous conduction, phase 1 alone in continuous conduction, or phase 1 alone with diode emulation. The block drives a phase-2 enable, a diode-emulation enable, a compensation-switch control and a phase-1 low-side turn-off request.

Mode requests are deglitched in units of switching periods, which arrive as single-cycle ticks. A request to idle phase 2 must stay stable for a short window. A request for diode emulation must stay stable for a longer window. Any change on the select inputs restarts the window.

Entry into single-phase operation waits while a reference ramp is in progress. A reference-code change made during diode emulation pulls the regulator back to two-phase operation at once. Until soft-start reports done, the regulator is held in two-phase operation.

Top module: `phase_mode_ctrl`

## Requirements
- R1: The select codes 001, 011 and 111 on `sel_req` (bit 2 is the first select, bit 0 the third) request two-phase mode. Once in two-phase mode, `ph2_en`=1, `de_en`=0 and `comp_sw`=0. `ph2_en` rises at the second rising clock edge after such a code is applied, and not at the first.
- R2: The codes 000, 010 and 110 request single-phase continuous mode. Once entered, `ph2_en`=0, `de_en`=0 and `comp_sw`=1.
- R3: The codes 100 and 101 request diode emulation. Once entered, `de_en`=1, `ph2_en`=0 and `comp_sw`=1.
- R4: While `ss_done` is low, the block is in two-phase mode from the next clock edge on, whatever `sel_req` holds.
- R5: Single-phase continuous mode is entered only after `sel_req` has held its code for IDLE_PERIODS ticks of `period_tick`. The mode changes at the clock edge that follows the tick that completes the count.
- R6: Diode emulation is entered only after `sel_req` has held its code for DE_PERIODS ticks. The mode changes at the clock edge that follows the completing tick.
- R7: A change of `sel_req` restarts the tick count, even when the new code requests the same mode.
- R8: While `ramp_busy` is high, no entry into single-phase or diode-emulation mode takes place. The entry follows at the first clock edge with `ramp_busy` low once the tick count has been met.
- R9: A `ref_chg` pulse during diode emulation returns the block to two-phase mode at the next clock edge. The pulse also restarts the tick count.
- R10: `lsd1_off` follows `zc_flag` combinationally while in diode emulation. `lsd1_off` is 0 in every other mode.
- R11: From diode emulation, a single-phase continuous code leads to single-phase continuous mode after IDLE_PERIODS ticks.
- R12: During reset, `ph2_en`=1, `de_en`=0, `comp_sw`=0 and `lsd1_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 3 | Power-saving selects, bit 2 first, bit 0 third |
| period_tick | input | 1 | One-cycle pulse per switching period |
| ss_done | input | 1 | Soft-start complete |
| ramp_busy | input | 1 | Reference ramp in progress |
| ref_chg | input | 1 | Reference-code change strobe |
| zc_flag | input | 1 | Phase-1 zero-current detect |
| ph2_en | output | 1 | Phase 2 switching; low holds both phase-2 drives off |
| de_en | output | 1 | Diode emulation active |
| comp_sw | output | 1 | Compensation switch closed (single-phase) |
| lsd1_off | output | 1 | Request to turn off the phase-1 low-side switch |

## Verification
The bench builds the block with its default windows of 2 periods for idling and 7 for diode emulation. These windows are short enough to test each threshold one tick below and exactly at its value. They also allow a select change in the middle of a window and a count that completes while a ramp is still running.

// File: rtl/phase_mode_ctrl.sv
module phase_mode_ctrl #(
  parameter int IDLE_PERIODS = 2,
  parameter int DE_PERIODS   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_req,
  input  logic       period_tick,
  input  logic       ss_done,
  input  logic       ramp_busy,
  input  logic       ref_chg,
  input  logic       zc_flag,
  output logic       ph2_en,
  output logic       de_en,
  output logic       comp_sw,
  output logic       lsd1_off
);
  localparam int MAXC = (IDLE_PERIODS > DE_PERIODS) ? IDLE_PERIODS : DE_PERIODS;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {M_DUAL = 2'd0, M_SINGLE = 2'd1, M_DIODE = 2'd2} mode_t;

  mode_t         mode, target;
  logic [2:0]    sel_q;
  logic [CW-1:0] stab;
  logic          sel_moved, count_met;

  assign sel_moved = (sel_req != sel_q);

  always_comb begin
    if (sel_q[2] && !sel_q[1]) target = M_DIODE;
    else if (sel_q[0])         target = M_DUAL;
    else                       target = M_SINGLE;
  end

  assign count_met = (target == M_DIODE) ? (stab >= CW'(DE_PERIODS))
                                         : (stab >= CW'(IDLE_PERIODS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 3'b001;
      stab  <= '0;
    end else if (sel_moved) begin
      sel_q <= sel_req;
      stab  <= '0;
    end else if (mode == M_DIODE && ref_chg && ss_done) begin
      stab  <= '0;
    end else if (period_tick && stab < CW'(MAXC)) begin
      stab  <= stab + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            mode <= M_DUAL;
    else if (!ss_done)                     mode <= M_DUAL;
    else if (mode == M_DIODE && ref_chg)   mode <= M_DUAL;
    else if (target == M_DUAL)             mode <= M_DUAL;
    else if (!ramp_busy && count_met)      mode <= target;
  end

  assign ph2_en   = (mode == M_DUAL);
  assign de_en    = (mode == M_DIODE);
  assign comp_sw  = (mode != M_DUAL);
  assign lsd1_off = de_en & zc_flag;
endmodule

module phase_mode_ctrl_chk #(
  parameter int IDLE_PERIODS = 2,
  parameter int DE_PERIODS   = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel_req,
  input logic       period_tick,
  input logic       ss_done,
  input logic       ramp_busy,
  input logic       ref_chg,
  input logic       zc_flag,
  input logic       ph2_en,
  input logic       de_en,
  input logic       comp_sw,
  input logic       lsd1_off
);
  logic [2:0] seen_sel;
  logic [7:0] seen_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_sel   <= 3'b001;
      seen_ticks <= '0;
    end else if (sel_req != seen_sel) begin
      seen_sel   <= sel_req;
      seen_ticks <= '0;
    end else if (period_tick && seen_ticks != 8'hFF) begin
      seen_ticks <= seen_ticks + 1'b1;
    end
  end

  // R4
  softstart_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> ph2_en);
  // R5
  idle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph2_en) |-> $past(seen_ticks) >= 8'(IDLE_PERIODS));
  // R6
  de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_en) |-> $past(seen_ticks) >= 8'(DE_PERIODS));
  // R8
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph2_en) |-> !$past(ramp_busy));
  // R9
  refchg_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_en && ref_chg) |=> ph2_en);
  // R10
  lsd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsd1_off |-> !ph2_en && !$isunknown(zc_flag));
endmodule

bind phase_mode_ctrl phase_mode_ctrl_chk #(
  .IDLE_PERIODS(IDLE_PERIODS), .DE_PERIODS(DE_PERIODS)
) u_chk (.*);

// File: tb/phase_mode_ctrl_test.sv
module phase_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_req = 3'b001;
  logic       period_tick = 1'b0, ss_done = 1'b0, ramp_busy = 1'b0;
  logic       ref_chg = 1'b0, zc_flag = 1'b0;
  logic       ph2_en, de_en, comp_sw, lsd1_off;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_mode_ctrl uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_mode(input string req, input bit e2, input bit ede, input bit ecs);
    check(ph2_en == e2,   req, "ph2_en",  int'(ph2_en),  int'(e2));
    check(de_en == ede,   req, "de_en",   int'(de_en),   int'(ede));
    check(comp_sw == ecs, req, "comp_sw", int'(comp_sw), int'(ecs));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      period_tick = 1'b1; @(negedge clk);
      period_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic apply(input logic [2:0] s);
    sel_req = s; @(negedge clk);
  endtask

  task automatic go_dual();
    apply(3'b001); cycles(2);
  endtask

  task automatic t_reset();
    cycles(3);
    check_mode("R12", 1'b1, 1'b0, 1'b0);
    check(lsd1_off == 1'b0, "R12", "lsd1_off", int'(lsd1_off), 0);
  endtask

  task automatic t_softstart();
    rst_n = 1'b1;
    apply(3'b100); ticks(9); cycles(2);
    check_mode("R4", 1'b1, 1'b0, 1'b0);
    ss_done = 1'b1; cycles(1);
    check_mode("R6", 1'b0, 1'b1, 1'b1);
    ss_done = 1'b0; cycles(1);
    check_mode("R4", 1'b1, 1'b0, 1'b0);
    ss_done = 1'b1;
  endtask

  task automatic t_dual_codes();
    apply(3'b000); ticks(2); cycles(1);
    check_mode("R2", 1'b0, 1'b0, 1'b1);
    apply(3'b011);
    check(ph2_en == 1'b0, "R1", "ph2_en after one edge", int'(ph2_en), 0);
    cycles(1);
    check_mode("R1", 1'b1, 1'b0, 1'b0);
    apply(3'b010); ticks(2); cycles(1);
    apply(3'b111); cycles(1);
    check_mode("R1", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_idle_window();
    go_dual();
    apply(3'b000); ticks(1); cycles(3);
    check(ph2_en == 1'b1, "R5", "ph2_en after 1 tick", int'(ph2_en), 1);
    ticks(1);
    check_mode("R5", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_restart();
    go_dual();
    apply(3'b010); ticks(1);
    apply(3'b110); ticks(1); cycles(2);
    check(ph2_en == 1'b1, "R7", "ph2_en after restart", int'(ph2_en), 1);
    ticks(1);
    check_mode("R7", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_diode();
    go_dual();
    apply(3'b100); ticks(6); cycles(2);
    check_mode("R6", 1'b1, 1'b0, 1'b0);
    ticks(1);
    check_mode("R3", 1'b0, 1'b1, 1'b1);
    go_dual();
    apply(3'b101); ticks(7);
    check_mode("R3", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_lsd();
    zc_flag = 1'b1; #1;
    check(lsd1_off == 1'b1, "R10", "lsd1_off in DE", int'(lsd1_off), 1);
    zc_flag = 1'b0; #1;
    check(lsd1_off == 1'b0, "R10", "lsd1_off zc low", int'(lsd1_off), 0);
    go_dual();
    zc_flag = 1'b1; #1;
    check(lsd1_off == 1'b0, "R10", "lsd1_off in 2P", int'(lsd1_off), 0);
    zc_flag = 1'b0;
  endtask

  task automatic t_refchg();
    apply(3'b100); ticks(7);
    check(de_en == 1'b1, "R9", "de_en before strobe", int'(de_en), 1);
    ramp_busy = 1'b1; ref_chg = 1'b1; @(negedge clk); ref_chg = 1'b0;
    check_mode("R9", 1'b1, 1'b0, 1'b0);
    ticks(8);
    check_mode("R8", 1'b1, 1'b0, 1'b0);
    ramp_busy = 1'b0; cycles(1);
    check_mode("R8", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_ramp_single();
    go_dual();
    ramp_busy = 1'b1;
    apply(3'b000); ticks(3);
    check(ph2_en == 1'b1, "R8", "ph2_en during ramp", int'(ph2_en), 1);
    ramp_busy = 1'b0; cycles(1);
    check_mode("R8", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_de_to_single();
    go_dual();
    apply(3'b101); ticks(7);
    apply(3'b110); ticks(1); cycles(1);
    check(de_en == 1'b1, "R11", "de_en after 1 tick", int'(de_en), 1);
    ticks(1);
    check_mode("R11", 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_softstart();
    t_dual_codes();
    t_idle_window();
    t_restart();
    t_diode();
    t_lsd();
    go_dual();
    t_refchg();
    t_ramp_single();
    t_de_to_single();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule